// File: doc/BRIEF.md
# Configuration register slave on a two-wire serial bus

This block lets an external bus master read and change the configuration of a line transceiver over I2C. It watches SCL and SDA on the system clock, finds START and STOP conditions, answers only to its own 7-bit device address, and acknowledges every byte it accepts. A write names a register index and then streams data bytes into consecutive indices. A read first sets the index with a short write, then returns bytes from that index upward until the master stops acknowledging.

Each writable register has two indices. A byte written to the even index ORs its ones into the register. A byte written to the odd index clears the bits where it has ones. Reading either index returns the register. After each write a priority fix-up removes bit combinations that may not coexist. The registers drive the mode logic of the transceiver as parallel outputs.

The link state machine has nine states. IDLE waits for START. ADDR shifts in the address byte and either moves to ADDR_ACK on a match or drops back to IDLE. ADDR_ACK holds SDA low for one clock, then goes to INDEX for a write or RDATA for a read. INDEX shifts the register index and moves to INDEX_ACK, which leads to WDATA. WDATA shifts a data byte, commits it and moves to WDATA_ACK, which returns to WDATA. RDATA sends eight bits and then enters RDATA_ACK. RDATA_ACK samples the master's answer: ACK returns to RDATA with the next byte, NACK goes to IDLE. START from any state enters ADDR, and STOP from any state enters IDLE.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset `cfg_main` = 03h (bit 0 speed, bit 1 power-down), `cfg_pull` = 0Ch (bits 2 and 3 are the pull-downs), `cfg_aux` = 14h (bit 2 bidirectional, bit 4 upper direction bit), and `evt_latch`, `evt_fall_en`, `evt_rise_en` = 00h.
- R2: The device address is 0101_10s, where s is `addr_sel` captured while `rst_n` is low and held after it rises. The slave gives no ACK to any other address, and the transfer that follows has no effect.
- R3: The slave pulls SDA low during the ninth clock after a matching address byte, after the register index byte and after each write data byte.
- R4: Consecutive data bytes of one write go to index K, K+1 and so on. Consecutive bytes of one read come from K, K+1 and so on.
- R5: The set/clear index pairs are 04h/05h (`cfg_main`), 06h/07h (`cfg_pull`), 12h/13h (`cfg_aux`), 0Ah/0Bh (`evt_latch`), 0Ch/0Dh (`evt_fall_en`) and 0Eh/0Fh (`evt_rise_en`). Ones written to the even index set bits, ones written to the odd index clear bits, and zeros leave bits unchanged. A register changes only when a data byte is written to it.
- R6: Index 00h/01h returns 83h/04h and 02h/03h returns C4h/A0h, the two identifiers low byte first. Reading either index of a pair returns the register value. All bytes are sent MSB first.
- R7: If a write would leave `cfg_main` bit 6 (serial mode) and bit 3 (pass-through mode) both set, bit 3 is cleared.
- R8: In `cfg_pull`, bit 5 (bus drive) beats bit 6 (discharge), which beats bit 7 (charge). After any write at most one of the three is set, and the lower-priority bits are cleared.
- R9: Indices that are not implemented read 00h. Writes to them are acknowledged but change no register.
- R10: `sda_oe` changes only while the synchronised SCL is low.
- R11: When the master NACKs a read byte, the slave releases SDA and sends no more data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Device address LSB, captured during reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_o | output | 1 | SDA drive value (always 0, open-drain) |
| sda_oe | output | 1 | SDA pull-low enable |
| cfg_main | output | 8 | Speed, power-down, format and mode bits |
| cfg_pull | output | 8 | Line pull resistors and bus supply control |
| cfg_aux | output | 8 | Direction, bias and regulator bits |
| evt_latch | output | 8 | Latched event bits |
| evt_fall_en | output | 8 | Falling-edge event enables |
| evt_rise_en | output | 8 | Rising-edge event enables |

## Verification
The set/clear decoding is tried with patterns that overlap bits already set, so a set that overwrites instead of ORing, or a clear that ignores zeros, gives a different value. Writes of two bytes and reads of four bytes cross an index boundary and tell a correct increment from a stuck or doubled index. The two priority fix-ups are checked with writes that create each conflict from both directions. A foreign address, an unimplemented index, and the other `addr_sel` value after a second reset separate address matching from register decoding.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    localparam int NREG = 6;

    // Even index sets bits, index | 1 clears them
    localparam logic [7:0] REG_SET_IDX [NREG] = '{8'h04, 8'h06, 8'h12, 8'h0A, 8'h0C, 8'h0E};
    localparam logic [7:0] REG_RST_VAL [NREG] = '{8'h03, 8'h0C, 8'h14, 8'h00, 8'h00, 8'h00};

    localparam int SLOT_MAIN = 0;
    localparam int SLOT_PULL = 1;

    localparam int MAIN_PASSTHRU = 3;
    localparam int MAIN_SERIAL   = 6;
    localparam int PULL_BUS_DRV  = 5;
    localparam int PULL_DISCHRG  = 6;
    localparam int PULL_CHRG     = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INDEX,
        ST_INDEX_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } link_state_e;

    function automatic logic [7:0] resolve_reg(input int slot, input logic [7:0] v);
        logic [7:0] r;
        r = v;
        if (slot == SLOT_MAIN && r[MAIN_SERIAL]) begin
            r[MAIN_PASSTHRU] = 1'b0;
        end
        if (slot == SLOT_PULL) begin
            if (r[PULL_BUS_DRV]) begin
                r[PULL_DISCHRG] = 1'b0;
                r[PULL_CHRG]    = 1'b0;
            end else if (r[PULL_DISCHRG]) begin
                r[PULL_CHRG] = 1'b0;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
    assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
    import cfg_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_s,
    input  logic [6:0] dev_addr,
    input  logic [7:0] rd_byte,
    output logic       sda_oe,
    output logic [7:0] reg_idx,
    output logic       wr_en,
    output logic [7:0] wr_data
);
    link_state_e state;
    logic [3:0]  bit_cnt;
    logic [7:0]  shreg;
    logic [7:0]  idx;
    logic        rw_read;
    logic        master_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            idx        <= '0;
            rw_read    <= 1'b0;
            master_ack <= 1'b0;
        end else if (bus_start) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
        end else if (bus_stop) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR, ST_INDEX, ST_WDATA: begin
                    if (scl_rise && bit_cnt < 4'd8) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (scl_fall && bit_cnt == 4'd8) begin
                        if (state == ST_ADDR) begin
                            if (shreg[7:1] == dev_addr) begin
                                rw_read <= shreg[0];
                                state   <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_INDEX) begin
                            idx   <= shreg;
                            state <= ST_INDEX_ACK;
                        end else begin
                            idx   <= idx + 8'd1;
                            state <= ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rw_read) begin
                            shreg <= rd_byte;
                            idx   <= idx + 8'd1;
                            state <= ST_RDATA;
                        end else begin
                            state <= ST_INDEX;
                        end
                    end
                end
                ST_INDEX_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        state   <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            bit_cnt <= '0;
                            state   <= ST_RDATA_ACK;
                        end else begin
                            shreg   <= {shreg[6:0], 1'b1};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) begin
                        master_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (master_ack) begin
                            shreg   <= rd_byte;
                            idx     <= idx + 8'd1;
                            bit_cnt <= '0;
                            state   <= ST_RDATA;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        sda_oe  = 1'b0;
        wr_en   = 1'b0;
        wr_data = shreg;
        reg_idx = idx;
        unique case (state)
            ST_ADDR_ACK, ST_INDEX_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA: sda_oe = ~shreg[7];
            ST_WDATA: wr_en = scl_fall && bit_cnt == 4'd8 && !bus_start && !bus_stop;
            default: ;
        endcase
    end

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfg_i2c_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h0483,
    parameter logic [15:0] PRODUCT_ID = 16'hA0C4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] reg_idx,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_byte,
    output logic [7:0] regs [NREG]
);
    logic [NREG-1:0] hit;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic hit_set;
        logic hit_clr;
        logic [7:0] raw;

        assign hit_set = reg_idx == REG_SET_IDX[g];
        assign hit_clr = reg_idx == (REG_SET_IDX[g] | 8'h01);
        assign hit[g]  = hit_set | hit_clr;
        assign raw     = hit_set ? (regs[g] | wr_data) : (regs[g] & ~wr_data);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= REG_RST_VAL[g];
            end else if (wr_en && hit[g]) begin
                regs[g] <= resolve_reg(g, raw);
            end
        end
    end

    always_comb begin
        rd_byte = 8'h00;
        unique case (reg_idx)
            8'h00: rd_byte = VENDOR_ID[7:0];
            8'h01: rd_byte = VENDOR_ID[15:8];
            8'h02: rd_byte = PRODUCT_ID[7:0];
            8'h03: rd_byte = PRODUCT_ID[15:8];
            default: begin
                for (int k = 0; k < NREG; k++) begin
                    if (hit[k]) rd_byte = regs[k];
                end
            end
        endcase
    end

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
    import cfg_i2c_pkg::*;
#(
    parameter logic [5:0]  ADDR_HI    = 6'b010110,
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] VENDOR_ID  = 16'h0483,
    parameter logic [15:0] PRODUCT_ID = 16'hA0C4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_sel,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_o,
    output logic       sda_oe,
    output logic [7:0] cfg_main,
    output logic [7:0] cfg_pull,
    output logic [7:0] cfg_aux,
    output logic [7:0] evt_latch,
    output logic [7:0] evt_fall_en,
    output logic [7:0] evt_rise_en
);
    logic       addr_lsb;
    logic       scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [7:0] reg_idx, wr_data, rd_byte;
    logic       wr_en;
    logic [7:0] regs [NREG];

    // Address LSB follows the pin while reset is held, then freezes
    always_ff @(posedge clk) begin
        if (!rst_n) addr_lsb <= addr_sel;
    end

    i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    i2c_link_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
        .dev_addr({ADDR_HI, addr_lsb}), .rd_byte(rd_byte),
        .sda_oe(sda_oe), .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data)
    );

    cfg_regbank #(.VENDOR_ID(VENDOR_ID), .PRODUCT_ID(PRODUCT_ID)) bank_i (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en),
        .wr_data(wr_data), .rd_byte(rd_byte), .regs(regs)
    );

    assign sda_o       = 1'b0;
    assign cfg_main    = regs[0];
    assign cfg_pull    = regs[1];
    assign cfg_aux     = regs[2];
    assign evt_latch   = regs[3];
    assign evt_fall_en = regs[4];
    assign evt_rise_en = regs[5];

endmodule

// File: rtl/cfg_i2c_checker.sv
module cfg_i2c_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_oe,
    input logic       wr_en,
    input logic [7:0] cfg_main,
    input logic [7:0] cfg_pull,
    input logic [7:0] evt_fall_en
);
    // R10: the pull-low enable only moves while SCL is seen low
    p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

    // R7: serial and pass-through modes never coexist
    p_mode_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_main[6] && cfg_main[3]));

    // R8: at most one supply control bit
    p_supply_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_pull[7:5]));

    // R5: registers hold without a write strobe
    p_hold_main_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_main));

    p_hold_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(evt_fall_en));

endmodule

bind cfg_i2c_slave cfg_i2c_checker chk_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .wr_en(wr_en),
    .cfg_main(cfg_main), .cfg_pull(cfg_pull), .evt_fall_en(evt_fall_en)
);

// File: tb/cfg_i2c_slave_tb.sv
module cfg_i2c_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_sel = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_o, sda_oe, sda_line;
    logic [7:0] cfg_main, cfg_pull, cfg_aux, evt_latch, evt_fall_en, evt_rise_en;

    int checks = 0;
    int failures = 0;
    int unstable = 0;
    bit done = 1'b0;
    logic [7:0] rbuf [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_m & ~(sda_oe & ~sda_o);

    cfg_i2c_slave dut_i (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(scl_m), .sda_i(sda_line),
        .sda_o(sda_o), .sda_oe(sda_oe), .cfg_main(cfg_main), .cfg_pull(cfg_pull),
        .cfg_aux(cfg_aux), .evt_latch(evt_latch), .evt_fall_en(evt_fall_en),
        .evt_rise_en(evt_rise_en)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic sel);
        addr_sel = sel;
        rst_n = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(2*Q);
        sda_m = 1'b0; wait_clk(2*Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(2*Q);
        sda_m = 1'b1; wait_clk(2*Q);
    endtask

    // One clock with the master leaving v on the line; returns the level mid-high
    task automatic bus_bit(input logic v, output logic seen);
        logic a;
        sda_m = v; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        a = sda_line; wait_clk(Q);
        seen = sda_line;
        if (a !== seen) unstable++;
        wait_clk(Q - 2);
        scl_m = 1'b0; wait_clk(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            b[i] = s;
        end
        bus_bit(~ack, s);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] idx, input int n,
                      input logic [7:0] d0, input logic [7:0] d1, input string req);
        logic ak;
        bus_start();
        send_byte({a, 1'b0}, ak);
        check({req, " R3 address ack"}, ak, 1'b1);
        send_byte(idx, ak);
        check({req, " R3 index ack"}, ak, 1'b1);
        send_byte(d0, ak);
        check({req, " R3 data ack"}, ak, 1'b1);
        if (n > 1) begin
            send_byte(d1, ak);
            check({req, " R3 data ack"}, ak, 1'b1);
        end
        bus_stop();
    endtask

    task automatic rd(input logic [7:0] idx, input int n, input string req);
        logic ak;
        bus_start();
        send_byte({7'h2C, 1'b0}, ak);
        send_byte(idx, ak);
        check({req, " R3 index ack"}, ak, 1'b1);
        bus_stop();
        bus_start();
        send_byte({7'h2C, 1'b1}, ak);
        check({req, " R3 read address ack"}, ak, 1'b1);
        for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
        wait_clk(Q);
        check({req, " R11 released after NACK"}, sda_oe, 1'b0);
        bus_stop();
    endtask

    task automatic t_reset();
        check("R1 cfg_main", cfg_main, 8'h03);
        check("R1 cfg_pull", cfg_pull, 8'h0C);
        check("R1 cfg_aux", cfg_aux, 8'h14);
        check("R1 evt regs", {evt_latch, evt_fall_en, evt_rise_en}, 24'h0);
        check("R1 sda idle", sda_oe, 1'b0);
    endtask

    task automatic t_ids();
        rd(8'h00, 4, "R6");
        check("R6 R4 id byte 0", rbuf[0], 8'h83);
        check("R6 R4 id byte 1", rbuf[1], 8'h04);
        check("R6 R4 id byte 2", rbuf[2], 8'hC4);
        check("R6 R4 id byte 3", rbuf[3], 8'hA0);
    endtask

    task automatic t_setclr();
        wr(7'h2C, 8'h0C, 1, 8'hA5, 8'h00, "R5");
        check("R5 set", evt_fall_en, 8'hA5);
        wr(7'h2C, 8'h0D, 1, 8'h21, 8'h00, "R5");
        check("R5 clear", evt_fall_en, 8'h84);
        wr(7'h2C, 8'h0B, 1, 8'hFF, 8'h00, "R5");
        check("R5 other regs untouched", {evt_latch, evt_rise_en, cfg_aux}, 24'h000014);
        rd(8'h0C, 2, "R6");
        check("R6 read set index", rbuf[0], 8'h84);
        check("R6 read clear index", rbuf[1], 8'h84);
    endtask

    task automatic t_multi();
        wr(7'h2C, 8'h0E, 2, 8'h3C, 8'h0C, "R4");
        check("R4 set then clear", evt_rise_en, 8'h30);
        wr(7'h2C, 8'h12, 2, 8'h81, 8'h14, "R4");
        check("R4 cfg_aux pair", cfg_aux, 8'h81);
    endtask

    task automatic t_mode_excl();
        wr(7'h2C, 8'h04, 1, 8'h48, 8'h00, "R7");
        check("R7 both set, serial wins", cfg_main, 8'h43);
        wr(7'h2C, 8'h05, 1, 8'h40, 8'h00, "R7");
        wr(7'h2C, 8'h04, 1, 8'h08, 8'h00, "R7");
        check("R7 pass-through alone", cfg_main, 8'h0B);
        wr(7'h2C, 8'h04, 1, 8'h40, 8'h00, "R7");
        check("R7 serial added later", cfg_main, 8'h43);
    endtask

    task automatic t_supply();
        wr(7'h2C, 8'h06, 1, 8'hE0, 8'h00, "R8");
        check("R8 drive wins", cfg_pull, 8'h2C);
        wr(7'h2C, 8'h07, 1, 8'h20, 8'h00, "R8");
        wr(7'h2C, 8'h06, 1, 8'hC0, 8'h00, "R8");
        check("R8 discharge beats charge", cfg_pull, 8'h4C);
        wr(7'h2C, 8'h06, 1, 8'h80, 8'h00, "R8");
        check("R8 charge over discharge dropped", cfg_pull, 8'h4C);
    endtask

    task automatic t_unimpl();
        logic [7:0] m, p, a, l, f, r;
        m = cfg_main; p = cfg_pull; a = cfg_aux; l = evt_latch; f = evt_fall_en; r = evt_rise_en;
        wr(7'h2C, 8'h20, 2, 8'hFF, 8'hFF, "R9");
        check("R9 no register changed", {cfg_main, cfg_pull, cfg_aux, evt_latch},
              {m, p, a, l});
        check("R9 no event register changed", {evt_fall_en, evt_rise_en}, {f, r});
        rd(8'h20, 1, "R9");
        check("R9 reads zero", rbuf[0], 8'h00);
    endtask

    task automatic t_addr();
        logic ak;
        logic [7:0] f;
        f = evt_fall_en;
        bus_start();
        send_byte({7'h2D, 1'b0}, ak);
        check("R2 foreign address no ack", ak, 1'b0);
        send_byte(8'h0C, ak);
        send_byte(8'hFF, ak);
        bus_stop();
        check("R2 foreign write ignored", evt_fall_en, f);
        do_reset(1'b1);
        wr(7'h2D, 8'h0C, 1, 8'h11, 8'h00, "R2");
        check("R2 other address after reset", evt_fall_en, 8'h11);
        bus_start();
        send_byte({7'h2C, 1'b0}, ak);
        check("R2 old address refused", ak, 1'b0);
        bus_stop();
    endtask

    initial begin
        do_reset(1'b0);
        t_reset();
        t_ids();
        t_setclr();
        t_multi();
        t_mode_excl();
        t_supply();
        t_unimpl();
        t_addr();
        check("R10 SDA steady while SCL high", unstable, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule